// File: doc/BRIEF.md
# Transmit Jabber Lockout Timer

This block sits between a repeater's transmit request and its line driver and keeps a stuck or runaway transmission from holding the medium forever. While the transmitter is asked to run, the block counts bit-time strobes. Once the transmission has gone on without a break for more than a limit number of bit times, the block forces the gated transmit enable low for a fixed quiet interval, then lets the request through again.

Every lockout raises a sticky flag that a management interface can read and then clear with a one-cycle strobe. The limit and the quiet length are parameters; the defaults are a 65,536-bit-time limit and a 96-bit-time gap.

Top module: `jab_lockout_timer`

## Requirements
- R1: After synchronous reset the block is not in lockout, the run count is zero and `jab_flag` is 0.
- R2: Outside lockout, `tx_gated` equals `tx_req` in the same cycle (combinational pass-through).
- R3: Lockout begins at the clock edge that ends the (LIMIT+1)-th bit-time strobe seen with `tx_req` high and no break. `tx_gated` is low from the next cycle on.
- R4: In any cycle outside lockout, a low `tx_req` brings the run count back to zero. A new run then needs a full LIMIT+1 strobes again.
- R5: Lockout lasts exactly GAP bit-time strobes after the entry edge. During it `tx_req` is ignored and `tx_gated` stays low.
- R6: When the gap ends the run count restarts from zero. If the request is still high, `tx_gated` rises and a fresh LIMIT+1 strobes are needed before the next lockout.
- R7: `jab_flag` goes to 1 at the lockout entry edge and stays at 1 until a clear strobe arrives.
- R8: `stat_clr` high at a clock edge clears `jab_flag`. If a lockout entry happens at the same edge, the flag is set instead.
- R9: Cycles without a `bit_tick` strobe advance neither the run count nor the gap count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_req | input | 1 | Raw transmit request |
| stat_clr | input | 1 | Clears the sticky lockout flag |
| tx_gated | output | 1 | Transmit enable after lockout gating |
| jab_flag | output | 1 | Sticky lockout status |

## Verification
The bench aims at the off-by-one edges of the limit and the gap. It checks that the cut comes after exactly LIMIT+1 strobes and that quiet lasts exactly GAP strobes. A counter compared one step early or late would cut or release the transmitter a bit time off. Short drops of the request in the middle of a run must restart the count; a design that only paused the count would lock out too early. It also drives a clear strobe on the same edge as a lockout entry, where a clear-priority design would lose the event. It holds the strobe low during both phases to catch counters that run on the clock instead of on bit times.

// File: rtl/jab_pkg.sv
package jab_pkg;

    typedef enum logic {
        PH_PASS  = 1'b0,
        PH_QUIET = 1'b1
    } phase_e;

    typedef struct packed {
        logic tick;
        logic req;
    } bit_in_t;

    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/jab_run_counter.sv
module jab_run_counter
    import jab_pkg::*;
#(
    parameter int unsigned LIMIT = 65536
) (
    input  logic    clk,
    input  logic    rst,
    input  bit_in_t bi,
    input  logic    locked,
    output logic    expire
);
    localparam int unsigned CW = cnt_bits(LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] run_cnt;

    assign expire = bi.req && !locked && bi.tick && (run_cnt == LIM_V);

    always_ff @(posedge clk) begin
        if (rst || !bi.req || locked) begin
            run_cnt <= '0;
        end else if (bi.tick) begin
            run_cnt <= (run_cnt == LIM_V) ? '0 : run_cnt + 1'b1;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LIM_V); // R3

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !bi.req |=> run_cnt == '0); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bi.tick && bi.req && !locked) |=> $stable(run_cnt)); // R9
endmodule

// File: rtl/jab_gap_timer.sv
module jab_gap_timer
    import jab_pkg::*;
#(
    parameter int unsigned GAP = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic locked
);
    localparam int unsigned GW = cnt_bits(GAP - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

    phase_e        phase;
    logic [GW-1:0] gap_cnt;

    assign locked = (phase == PH_QUIET);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_PASS;
            gap_cnt <= '0;
        end else if (phase == PH_PASS) begin
            if (start) begin
                phase   <= PH_QUIET;
                gap_cnt <= '0;
            end
        end else if (tick) begin
            if (gap_cnt == GAP_LAST) begin
                phase   <= PH_PASS;
                gap_cnt <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_cnt <= GAP_LAST); // R5

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && !tick) |=> (locked && $stable(gap_cnt))); // R9
endmodule

// File: rtl/jab_status.sv
module jab_status (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R7

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> !flag); // R8
endmodule

// File: rtl/jab_lockout_timer.sv
module jab_lockout_timer
    import jab_pkg::*;
#(
    parameter int unsigned LIMIT = 65536,
    parameter int unsigned GAP   = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic stat_clr,
    output logic tx_gated,
    output logic jab_flag
);
    bit_in_t bi;
    logic    locked;
    logic    expire;

    assign bi.tick = bit_tick;
    assign bi.req  = tx_req;

    jab_run_counter #(.LIMIT(LIMIT)) u_run (
        .clk    (clk),
        .rst    (rst),
        .bi     (bi),
        .locked (locked),
        .expire (expire)
    );

    jab_gap_timer #(.GAP(GAP)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .start  (expire),
        .locked (locked)
    );

    jab_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_ev (expire),
        .clr    (stat_clr),
        .flag   (jab_flag)
    );

    assign tx_gated = tx_req && !locked;

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> !tx_gated); // R3

    AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> jab_flag); // R7
endmodule

// File: tb/jab_lockout_timer_tb.sv
module jab_lockout_timer_tb;
    localparam int unsigned LIM = 40;
    localparam int unsigned GP  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0, tx_req = 1'b0, stat_clr = 1'b0;
    logic tx_gated, jab_flag;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    int  m_cnt = 0, m_gap = 0;
    bit  m_lock = 1'b0, m_stat = 1'b0;

    always #2 clk = ~clk;

    jab_lockout_timer #(.LIMIT(LIM), .GAP(GP)) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_req(tx_req),
        .stat_clr(stat_clr), .tx_gated(tx_gated), .jab_flag(jab_flag)
    );

    function automatic bit exp_en(bit req, bit lk);
        return req && !lk;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, check outputs, then advance the reference model
    task automatic step(bit tk, bit rq, bit cl, string tag);
        bit set_ev;
        @(negedge clk);
        bit_tick = tk; tx_req = rq; stat_clr = cl;
        #1;
        chk({tag, " tx_gated"}, tx_gated, exp_en(rq, m_lock));
        chk({tag, " jab_flag"}, jab_flag, m_stat);
        @(posedge clk);
        set_ev = 1'b0;
        if (m_lock) begin
            if (tk) begin
                if (m_gap == GP - 1) begin m_lock = 0; m_gap = 0; m_cnt = 0; end
                else m_gap++;
            end
        end else if (!rq) begin
            m_cnt = 0;
        end else if (tk) begin
            if (m_cnt == LIM) begin set_ev = 1; m_lock = 1; m_gap = 0; m_cnt = 0; end
            else m_cnt++;
        end
        if (set_ev) m_stat = 1;
        else if (cl) m_stat = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        chk("R1 flag", jab_flag, 1'b0);
        chk("R1 gated", tx_gated, 1'b0);
        // R2: pass-through
        step(0, 1, 0, "R2");
        step(1, 0, 0, "R2");
        // R3: full run then cut after LIM+1 strobes
        for (int i = 0; i < LIM + 1; i++) step(1, 1, 0, "R3");
        #1 chk("R3 cut", tx_gated, 1'b0);
        chk("R7 flag set", jab_flag, 1'b1);
        // R9: no strobes during quiet keeps lockout
        for (int i = 0; i < 20; i++) step(0, 1, 0, "R9");
        // R5: quiet lasts GP strobes, request ignored
        for (int i = 0; i < GP; i++) step(1, 1, 0, "R5");
        #1 chk("R6 release", tx_gated, 1'b1);
        // R6 fresh run; R4 drop mid-run
        for (int i = 0; i < LIM - 2; i++) step(1, 1, 0, "R6");
        step(1, 0, 0, "R4");
        for (int i = 0; i < LIM; i++) step(1, 1, 0, "R4");
        #1 chk("R4 no early cut", tx_gated, 1'b1);
        // R9: many idle cycles with request high do not count
        for (int i = 0; i < 100; i++) step(0, 1, 0, "R9");
        // R8: clear at the same edge as a new entry -> set wins
        step(1, 1, 1, "R8");
        #1 chk("R8 set wins", jab_flag, 1'b1);
        for (int i = 0; i < GP; i++) step(1, 0, 0, "R5");
        step(0, 0, 1, "R8");
        #1 chk("R8 cleared", jab_flag, 1'b0);
        // random mix
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, ($urandom % 60) != 0, ($urandom % 25) == 0, "RND R7");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule